// File: doc/BRIEF.md
# Multimode General-Purpose Timer

This unit is a programmable timer that runs on the system clock and shares one counter among three modes. In waveform mode it drives `pwm_o` with a programmable period and high time. In capture mode it measures how long an input pulse stays active and how far apart its leading edges are, both counted in clock cycles. In counting mode it advances either on every clock or on each rising edge of the external input, and reloads at a programmable limit.

Software reaches the block through a small register port: a control word, a period register, a width register, a read-only counter view and a status word. The status word holds an interrupt flag and an overflow flag, and both stay set until software clears them. An input-polarity control lets capture mode time a low-going pulse, so software can read one bit time from a serial line that idles high and derive the baud rate from it.

Top module: `mtimer`

## Requirements
- R1: After reset every register reads zero, `pwm_o` and `irq_o` are low, and the counter reads 0.
- R2: While CTRL bit 0 (enable) is 0, the counter is held at 0 and `pwm_o` is low. In the cycle after the write that sets enable, COUNT reads 0, and it advances from there on each later clock.
- R3: Waveform mode (CTRL[2:1]=0) counts 0,1,...,PERIOD-1 and then reloads to 0. `pwm_o` is high exactly while COUNT < WIDTH: it is low throughout when WIDTH=0 and high throughout when WIDTH >= PERIOD.
- R4: Each reload in waveform or counting mode sets STATUS bit 0 on the same clock edge.
- R5: STATUS bits stay set until a write to STATUS with 1 in that bit position. Writing 0 to a bit leaves it unchanged. `irq_o` equals STATUS bit 0.
- R6: Counting mode (CTRL[2:1]=2) with CTRL bit 3 = 0 advances on every clock, counting 0..PERIOD-1 before it reloads.
- R7: Counting mode with CTRL bit 3 = 1 advances once per rising edge of `ext_i`, after a two-flop synchroniser. After N pulses COUNT reads N mod PERIOD, and STATUS bit 0 is set if N >= PERIOD.
- R8: Capture mode (CTRL[2:1]=1): the first active edge of the input starts the count. The following inactive edge stores the active time, in cycles, into WIDTH. The next active edge stores the edge-to-edge time into PERIOD, sets STATUS bit 0 and restarts the count. STATUS bit 0 stays clear until that second active edge.
- R9: CTRL bit 4 inverts `ext_i` before edge detection, so capture mode measures the low time of a line that idles high.
- R10: In capture mode, if the running count wraps from all ones to 0 before the closing active edge, STATUS bit 1 (overflow) is set.
- R11: Mode value 3 is reserved. In that mode the counter stays at 0, `pwm_o` stays low and no interrupt is raised.
- R12: Register addresses are 0 CTRL, 1 PERIOD, 2 WIDTH, 3 COUNT and 4 STATUS. Writes to COUNT are ignored, and reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` (combinational) |
| ext_i | input | 1 | External input for capture and event counting |
| pwm_o | output | 1 | Waveform output |
| irq_o | output | 1 | Interrupt request (STATUS bit 0) |

## Verification
The bench builds the timer with CNT_W=10 instead of the 32-bit default. With that width the counter reaches all ones within about a thousand cycles, so one held input pulse drives the capture overflow path and sets the overflow flag in a short run. Waveform periods, widths and capture pulse lengths are drawn small and random, so that several full periods and reload interrupts fit in each trial.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    typedef enum logic [1:0] {
        MD_PWM   = 2'd0,
        MD_CAPT  = 2'd1,
        MD_COUNT = 2'd2,
        MD_RSVD  = 2'd3
    } tmode_e;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_PERIOD = 3'd1;
    localparam logic [2:0] A_WIDTH  = 3'd2;
    localparam logic [2:0] A_COUNT  = 3'd3;
    localparam logic [2:0] A_STAT   = 3'd4;

    localparam int CTRL_W = 5;

    typedef struct packed {
        logic   inv;      // bit 4
        logic   ext_clk;  // bit 3
        tmode_e mode;     // bits 2:1
        logic   en;       // bit 0
    } ctrl_t;

    typedef struct packed {
        logic wrap;
        logic cap_w;
        logic cap_p;
        logic ovf;
    } evt_t;

    function automatic ctrl_t to_ctrl(input logic [CTRL_W-1:0] w);
        return ctrl_t'(w);
    endfunction

endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic inv,
    output logic rise,
    output logic fall
);
    logic s1, s2, prev;
    logic sig;

    assign sig = s2 ^ inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= pin;
            s2   <= s1;
            prev <= sig;
        end
    end

    assign rise = sig & ~prev;
    assign fall = ~sig & prev;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import mtimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] width,
    input  logic             rise,
    input  logic             fall,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_val,
    output logic             run_o,
    output logic             pwm_o,
    output evt_t             evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             run_q, run_d;
    logic             last, tick, adv, cap;

    always_comb begin
        last = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period};
        tick = ctrl.ext_clk ? rise : 1'b1;
        adv  = ctrl.en & ((ctrl.mode == MD_PWM) | ((ctrl.mode == MD_COUNT) & tick));
        cap  = ctrl.en & (ctrl.mode == MD_CAPT);

        evt.wrap  = adv & last;
        evt.cap_p = cap & rise & run_q;
        evt.cap_w = cap & fall & run_q;
        evt.ovf   = cap & run_q & ~rise & (cnt_q == CNT_MAX);

        cnt_d = cnt_q;
        run_d = 1'b0;
        if (!ctrl.en) begin
            cnt_d = '0;
        end else if (adv) begin
            cnt_d = last ? '0 : cnt_q + 1'b1;
        end else if (cap) begin
            run_d = run_q | rise;
            if (rise)       cnt_d = '0;
            else if (run_q) cnt_d = cnt_q + 1'b1;
        end else if (ctrl.mode == MD_RSVD) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    assign cnt_o   = cnt_q;
    assign run_o   = run_q;
    assign cap_val = cnt_q + 1'b1;
    assign pwm_o   = ctrl.en & (ctrl.mode == MD_PWM) & (cnt_q < width);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import mtimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] width,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cap_val,
    input  evt_t             evt,
    output logic             stat_irq,
    output logic             stat_ovf
);
    logic wr_ctrl, wr_per, wr_wid, wr_stat;

    assign wr_ctrl = bus_wr & (bus_addr == A_CTRL);
    assign wr_per  = bus_wr & (bus_addr == A_PERIOD);
    assign wr_wid  = bus_wr & (bus_addr == A_WIDTH);
    assign wr_stat = bus_wr & (bus_addr == A_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            period   <= '0;
            width    <= '0;
            stat_irq <= 1'b0;
            stat_ovf <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl <= to_ctrl(bus_wdata[CTRL_W-1:0]);
            if (evt.cap_p)   period <= cap_val;
            else if (wr_per) period <= bus_wdata;
            if (evt.cap_w)   width <= cap_val;
            else if (wr_wid) width <= bus_wdata;
            stat_irq <= evt.wrap | evt.cap_p | (stat_irq & ~(wr_stat & bus_wdata[0]));
            stat_ovf <= evt.ovf | (stat_ovf & ~(wr_stat & bus_wdata[1]));
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata[CTRL_W-1:0] = ctrl;
            A_PERIOD: bus_rdata = period;
            A_WIDTH:  bus_rdata = width;
            A_COUNT:  bus_rdata = cnt;
            A_STAT:   bus_rdata[1:0] = {stat_ovf, stat_irq};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mtimer.sv
module mtimer
    import mtimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             ext_i,
    output logic             pwm_o,
    output logic             irq_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] period, width, cnt, cap_val;
    logic             rise, fall, run, stat_irq, stat_ovf;
    evt_t             evt;

    tmr_edge u_edge (
        .clk (clk),
        .rst (rst),
        .pin (ext_i),
        .inv (ctrl.inv),
        .rise(rise),
        .fall(fall)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl),
        .period (period),
        .width  (width),
        .rise   (rise),
        .fall   (fall),
        .cnt_o  (cnt),
        .cap_val(cap_val),
        .run_o  (run),
        .pwm_o  (pwm_o),
        .evt    (evt)
    );

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ctrl     (ctrl),
        .period   (period),
        .width    (width),
        .cnt      (cnt),
        .cap_val  (cap_val),
        .evt      (evt),
        .stat_irq (stat_irq),
        .stat_ovf (stat_ovf)
    );

    assign irq_o = stat_irq;
endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk
    import mtimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input tmode_e           mode,
    input logic [CNT_W-1:0] cnt,
    input logic             run,
    input logic             rise,
    input logic             pwm_o,
    input logic             irq_o,
    input logic             stat_ovf,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [CNT_W-1:0] bus_wdata
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R2: a cycle spent disabled leaves the counter at zero
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> cnt == '0);

    // R2: output low while disabled
    a_r2_idle_low: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pwm_o);

    // R4: a waveform-mode reload raises the interrupt
    a_r4_reload_irq: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && mode == MD_PWM && $past(mode) == MD_PWM
         && $past(cnt) != '0 && cnt == '0) |-> irq_o);

    // R5: interrupt flag sticky unless cleared by a 1 write
    a_r5_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_o) && !($past(bus_wr) && $past(bus_addr) == A_STAT
                           && $past(bus_wdata[0]))) |-> irq_o);

    // R10: overflow flag sticky unless cleared by a 1 write
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(stat_ovf) && !($past(bus_wr) && $past(bus_addr) == A_STAT
                              && $past(bus_wdata[1]))) |-> stat_ovf);

    // R8: a running capture count steps by one between active edges
    a_r8_cap_step: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && mode == MD_CAPT && $past(mode) == MD_CAPT
         && $past(run) && !$past(rise) && $past(cnt) != CNT_MAX)
        |-> cnt == $past(cnt) + 1'b1);

    // R11: reserved mode keeps the counter at zero
    a_r11_rsvd_idle: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == MD_RSVD && mode == MD_RSVD) |-> (cnt == '0 && !pwm_o));
endmodule

bind mtimer mtimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (ctrl.en),
    .mode     (ctrl.mode),
    .cnt      (cnt),
    .run      (run),
    .rise     (rise),
    .pwm_o    (pwm_o),
    .irq_o    (irq_o),
    .stat_ovf (stat_ovf),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata)
);

// File: tb/mtimer_bench.sv
module mtimer_bench;
    localparam int CW  = 10;
    localparam int CLK = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;
    logic          ext_i = 1'b0;
    logic          pwm_o, irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK/2) clk = ~clk;

    mtimer #(.CNT_W(CW)) u_mtimer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_i(ext_i),
        .pwm_o(pwm_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = CW'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = 3'(a);
        #1;
        v = int'(bus_rdata);
    endtask

    function automatic int ctrl_word(input int en, input int md, input int ext, input int inv);
        return en | (md << 1) | (ext << 3) | (inv << 4);
    endfunction

    function automatic bit pwm_exp(input int k, input int p, input int w);
        return (k % p) < w;
    endfunction

    task automatic run_pwm(input int p, input int w);
        int v;
        wr(0, 0); wr(1, p); wr(2, w); wr(4, 3);
        wr(0, ctrl_word(1, 0, 0, 0));
        rd(3, v); chk(v == 0, "R2 count starts at 0", v, 0);
        for (int k = 0; k < 2 * p; k++) begin
            rd(3, v);
            chk(v == k % p, "R3 waveform count", v, k % p);
            chk(pwm_o == pwm_exp(k, p, w), "R3 pwm level", int'(pwm_o), int'(pwm_exp(k, p, w)));
            if (k == p - 1) chk(irq_o == 1'b0, "R4 no irq before reload", int'(irq_o), 0);
            if (k == p)     chk(irq_o == 1'b1, "R4 irq at reload", int'(irq_o), 1);
            @(negedge clk);
        end
    endtask

    task automatic run_cap(input int h, input int l, input int inv);
        int v;
        wr(0, 0);
        ext_i = inv[0];
        repeat (4) @(negedge clk);
        wr(4, 3);
        wr(0, ctrl_word(1, 1, 0, inv));
        repeat (3) @(negedge clk);
        ext_i = ~inv[0];
        repeat (h) @(negedge clk);
        ext_i = inv[0];
        repeat (l) @(negedge clk);
        chk(irq_o == 1'b0, "R8 irq clear before closing edge", int'(irq_o), 0);
        ext_i = ~inv[0];
        repeat (4) @(negedge clk);
        rd(2, v); chk(v == h, inv ? "R9 inverted width" : "R8 width", v, h);
        rd(1, v); chk(v == h + l, inv ? "R9 inverted period" : "R8 period", v, h + l);
        chk(irq_o == 1'b1, "R8 irq after period", int'(irq_o), 1);
        ext_i = inv[0];
    endtask

    initial begin
        int v, p, w, n, m;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(a, v); chk(v == 0, "R1 register reset", v, 0);
        end
        chk(pwm_o == 1'b0 && irq_o == 1'b0, "R1 outputs low", int'({pwm_o, irq_o}), 0);

        // R2 disabled holds zero
        wr(1, 5); wr(2, 3);
        wr(0, ctrl_word(0, 0, 0, 0));
        repeat (6) @(negedge clk);
        rd(3, v); chk(v == 0, "R2 disabled count", v, 0);
        chk(pwm_o == 1'b0, "R2 disabled pwm low", int'(pwm_o), 0);

        // R3/R4 directed corners then random
        run_pwm(4, 0);
        run_pwm(4, 4);
        run_pwm(3, 7);
        for (int t = 0; t < 8; t++) begin
            p = 2 + int'($urandom_range(0, 18));
            w = int'($urandom_range(0, p + 2));
            run_pwm(p, w);
        end

        // R5 W1C behaviour
        chk(irq_o == 1'b1, "R5 irq still set", int'(irq_o), 1);
        wr(0, 0);
        wr(4, 2);
        rd(4, v); chk(v[0] == 1'b1, "R5 writing 0 keeps irq", v, 1);
        wr(4, 1);
        rd(4, v); chk(v[0] == 1'b0, "R5 W1C clears irq", v, 0);
        chk(irq_o == 1'b0, "R5 irq_o follows status", int'(irq_o), 0);

        // R6 internal counting
        for (int t = 0; t < 3; t++) begin
            p = 3 + int'($urandom_range(0, 10));
            m = int'($urandom_range(1, 30));
            wr(0, 0); wr(1, p); wr(4, 3);
            wr(0, ctrl_word(1, 2, 0, 0));
            repeat (m) @(negedge clk);
            rd(3, v); chk(v == m % p, "R6 internal count", v, m % p);
            chk(irq_o == (m >= p), "R6 reload irq", int'(irq_o), int'(m >= p));
        end

        // R7 external edge counting
        for (int t = 0; t < 4; t++) begin
            p = 3 + int'($urandom_range(0, 5));
            n = int'($urandom_range(1, 12));
            wr(0, 0); ext_i = 1'b0;
            repeat (4) @(negedge clk);
            wr(1, p); wr(4, 3);
            wr(0, ctrl_word(1, 2, 1, 0));
            for (int i = 0; i < n; i++) begin
                ext_i = 1'b1; repeat (2) @(negedge clk);
                ext_i = 1'b0; repeat (2) @(negedge clk);
            end
            repeat (3) @(negedge clk);
            rd(3, v); chk(v == n % p, "R7 edge count", v, n % p);
            chk(irq_o == (n >= p), "R7 reload irq", int'(irq_o), int'(n >= p));
        end

        // R8 capture, R9 inverted capture
        run_cap(1, 1, 0);
        for (int t = 0; t < 3; t++)
            run_cap(int'($urandom_range(1, 30)), int'($urandom_range(1, 30)), 0);
        for (int t = 0; t < 3; t++)
            run_cap(int'($urandom_range(1, 30)), int'($urandom_range(1, 30)), 1);

        // R10 overflow
        wr(0, 0); ext_i = 1'b0;
        repeat (4) @(negedge clk);
        wr(4, 3);
        wr(0, ctrl_word(1, 1, 0, 0));
        repeat (3) @(negedge clk);
        ext_i = 1'b1;
        repeat (1100) @(negedge clk);
        rd(4, v); chk(v[1] == 1'b1, "R10 overflow set", v, 2);
        chk(irq_o == 1'b0, "R10 no irq on overflow", int'(irq_o), 0);
        wr(4, 2);
        rd(4, v); chk(v[1] == 1'b0, "R10 overflow cleared", v, 0);
        ext_i = 1'b0;

        // R11 reserved mode
        wr(0, 0); wr(4, 3); wr(1, 2);
        wr(0, ctrl_word(1, 3, 0, 0));
        repeat (10) @(negedge clk);
        rd(3, v); chk(v == 0, "R11 reserved count", v, 0);
        chk(pwm_o == 1'b0 && irq_o == 1'b0, "R11 reserved quiet", int'({pwm_o, irq_o}), 0);

        // R12 map details
        wr(3, 55);
        rd(3, v); chk(v == 0, "R12 count write ignored", v, 0);
        rd(0, v); chk(v == ctrl_word(1, 3, 0, 0), "R12 ctrl readback", v, ctrl_word(1, 3, 0, 0));
        rd(7, v); chk(v == 0, "R12 unmapped read", v, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule